// File: doc/BRIEF.md
# Interrupt Cause Bank

This block gathers interrupt causes for three groups of events (receive, transmit and miscellaneous) and reduces them to one level-sensitive interrupt line. Each group has its own 32-bit cause register, fed by single-cycle event pulses from hardware. Each group also has a mask with separate set and clear strobes, a software port that raises causes directly, and a per-bit selection of how a cause is acknowledged. A cause can be acknowledged either by writing a 1 to it or just by reading the cause register.

A three-bit summary word sits above the groups. It records which groups hold an unmasked cause, and reading it acknowledges it. A software mask over the summary decides which groups may drive the interrupt pin. The register port is a plain synchronous bus with address, write enable, read enable, write data and read data. Read data is combinational and valid in the cycle the address is presented. Any clear caused by a read takes effect at the end of that cycle.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause register and every clear-mode register reads 0, every group mask and the summary mask read all ones, the summary reads 0 and `irq_o` is low.
- R2: An event pulse on bit b of a group sets cause bit b at the next clock edge. The bit stays set whether or not it is masked, until it is acknowledged.
- R3: For a bit whose clear mode is 0, writing a 1 to that bit at the group's cause address clears it. Writing 0 leaves it set, and reading the cause register does not clear it.
- R4: For a bit whose clear mode is 1, reading the cause register returns the bit and clears it at the end of that cycle. Writing a 1 to it at the cause address has no effect.
- R5: A write to the mask-set address sets each mask bit where the data is 1. A write to the mask-clear address clears each mask bit where the data is 1. Bits written as 0 keep their value. The mask reads back at its own read-only address.
- R6: A write to the cause-set address sets each cause bit where the data is 1.
- R7: Summary bit 0 (receive), bit 1 (transmit) and bit 2 (miscellaneous) each become 1 one cycle after their group holds any cause bit whose mask bit is 0.
- R8: Reading the summary clears it. A group whose unmasked cause is still pending at that read is set again on the next cycle. A summary bit stays set after its cause is acknowledged until the summary is read.
- R9: `irq_o` is high exactly while some summary bit is 1 and the matching bit of the summary mask is 0. Writing the summary mask with its low three bits cleared lets all groups through.
- R10: If an event pulse and a clear (by read or by write-1) hit the same cause bit in the same cycle, the bit stays set.
- R11: Group g (receive 0, transmit 1, miscellaneous 2) occupies word addresses 8g+0 (cause, read/write-1), 8g+1 (cause set), 8g+2 (mask set), 8g+3 (mask clear), 8g+4 (mask, read-only) and 8g+5 (clear mode). The summary is at 24 and its mask at 25. Reads of write-only or unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Word address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (triggers clear-on-read) |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from address |
| rx_evt_i | input | DW | Receive event pulses, one per cause bit |
| tx_evt_i | input | DW | Transmit event pulses, one per cause bit |
| misc_evt_i | input | DW | Miscellaneous event pulses, one per cause bit |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that a bus cycle is either a read or a write, never both at once. Otherwise a mask-set or cause-clear check could be overridden by a concurrent access to the same register. The bench never raises both strobes together. It changes the bus and event inputs only at the falling edge, so every sampled property sees stable inputs. It also inserts an idle cycle before each summary read, so that the latched summary has caught up with the causes the assertions relate it to.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int NGRP       = 3;
    localparam int GRP_RX     = 0;
    localparam int GRP_TX     = 1;
    localparam int GRP_MISC   = 2;

    localparam int GRP_STRIDE = 8;
    localparam int OFF_CAUSE  = 0;
    localparam int OFF_CSET   = 1;
    localparam int OFF_MSET   = 2;
    localparam int OFF_MCLR   = 3;
    localparam int OFF_MASK   = 4;
    localparam int OFF_MODE   = 5;

    localparam int ADDR_SUM   = NGRP * GRP_STRIDE;
    localparam int ADDR_SMASK = ADDR_SUM + 1;

    // per-group access strobes produced by the address decoder
    typedef struct packed {
        logic cause_rd;
        logic cause_w1c;
        logic cause_set;
        logic mask_set;
        logic mask_clr;
        logic mode_wr;
    } grp_strb_t;

endpackage

// File: rtl/irq_grp_regs.sv
module irq_grp_regs #(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  irq_bank_pkg::grp_strb_t strb_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [DW-1:0]           evt_i,
    output logic [DW-1:0]           cause_o,
    output logic [DW-1:0]           mask_o,
    output logic [DW-1:0]           mode_o,
    output logic                    any_o
);

    typedef struct packed {
        logic [DW-1:0] cause;
        logic [DW-1:0] mask;
        logic [DW-1:0] mode;
    } grp_state_t;

    grp_state_t    st_d, st_q;
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] set_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        // read clears the bits in clear-on-read mode
        if (strb_i.cause_rd) begin
            clr_bits = clr_bits | st_q.mode;
        end
        // write-one clears only the bits in write-1 mode
        if (strb_i.cause_w1c) begin
            clr_bits = clr_bits | (wdata_i & ~st_q.mode);
        end
        set_bits = evt_i;
        if (strb_i.cause_set) begin
            set_bits = set_bits | wdata_i;
        end
        // set sources are applied after the clear so an event wins
        st_d.cause = (st_q.cause & ~clr_bits) | set_bits;

        if (strb_i.mask_set) begin
            st_d.mask = st_d.mask | wdata_i;
        end
        if (strb_i.mask_clr) begin
            st_d.mask = st_d.mask & ~wdata_i;
        end
        if (strb_i.mode_wr) begin
            st_d.mode = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cause <= '0;
            st_q.mask  <= '1;
            st_q.mode  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign mode_o  = st_q.mode;
    assign any_o   = |(st_q.cause & ~st_q.mask);

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
    parameter int AW   = 6,
    parameter int DW   = 32,
    parameter int NGRP = irq_bank_pkg::NGRP
) (
    input  logic [AW-1:0]           addr_i,
    input  logic                    wr_en_i,
    input  logic                    rd_en_i,
    input  logic [DW-1:0]           cause_i [NGRP],
    input  logic [DW-1:0]           mask_i  [NGRP],
    input  logic [DW-1:0]           mode_i  [NGRP],
    input  logic [NGRP-1:0]         sum_i,
    input  logic [DW-1:0]           smask_i,
    output irq_bank_pkg::grp_strb_t strb_o  [NGRP],
    output logic                    sum_rd_o,
    output logic                    smask_wr_o,
    output logic [DW-1:0]           rdata_o
);
    import irq_bank_pkg::*;

    localparam logic [AW-1:0] SUM_A   = AW'(ADDR_SUM);
    localparam logic [AW-1:0] SMASK_A = AW'(ADDR_SMASK);

    for (genvar g = 0; g < NGRP; g++) begin : g_strb
        localparam logic [AW-1:0] BASE = AW'(g * GRP_STRIDE);
        assign strb_o[g] = '{
            cause_rd:  rd_en_i && (addr_i == BASE + AW'(OFF_CAUSE)),
            cause_w1c: wr_en_i && (addr_i == BASE + AW'(OFF_CAUSE)),
            cause_set: wr_en_i && (addr_i == BASE + AW'(OFF_CSET)),
            mask_set:  wr_en_i && (addr_i == BASE + AW'(OFF_MSET)),
            mask_clr:  wr_en_i && (addr_i == BASE + AW'(OFF_MCLR)),
            mode_wr:   wr_en_i && (addr_i == BASE + AW'(OFF_MODE))
        };
    end

    assign sum_rd_o   = rd_en_i && (addr_i == SUM_A);
    assign smask_wr_o = wr_en_i && (addr_i == SMASK_A);

    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (addr_i == AW'(g * GRP_STRIDE + OFF_CAUSE)) begin
                rdata_o = cause_i[g];
            end
            if (addr_i == AW'(g * GRP_STRIDE + OFF_MASK)) begin
                rdata_o = mask_i[g];
            end
            if (addr_i == AW'(g * GRP_STRIDE + OFF_MODE)) begin
                rdata_o = mode_i[g];
            end
        end
        if (addr_i == SUM_A) begin
            rdata_o = {{(DW-NGRP){1'b0}}, sum_i};
        end
        if (addr_i == SMASK_A) begin
            rdata_o = smask_i;
        end
    end

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int DW   = 32,
    parameter int NGRP = irq_bank_pkg::NGRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] any_i,
    input  logic            sum_rd_i,
    input  logic            smask_wr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [NGRP-1:0] sum_o,
    output logic [DW-1:0]   smask_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [NGRP-1:0] sum;
        logic [DW-1:0]   smask;
    } sum_state_t;

    sum_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // sticky until read; a still-pending group re-latches at once
        st_d.sum = any_i | (st_q.sum & ~{NGRP{sum_rd_i}});
        if (smask_wr_i) begin
            st_d.smask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sum   <= '0;
            st_q.smask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o   = st_q.sum;
    assign smask_o = st_q.smask;
    assign irq_o   = |(st_q.sum & ~st_q.smask[NGRP-1:0]);

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] rx_evt_i,
    input  logic [DW-1:0] tx_evt_i,
    input  logic [DW-1:0] misc_evt_i,
    output logic          irq_o
);
    import irq_bank_pkg::*;

    logic [DW-1:0]   evt_w   [NGRP];
    logic [DW-1:0]   cause_w [NGRP];
    logic [DW-1:0]   mask_w  [NGRP];
    logic [DW-1:0]   mode_w  [NGRP];
    grp_strb_t       strb_w  [NGRP];
    logic [NGRP-1:0] any_w;
    logic [NGRP-1:0] sum_w;
    logic [DW-1:0]   smask_w;
    logic            sum_rd_w;
    logic            smask_wr_w;

    assign evt_w[GRP_RX]   = rx_evt_i;
    assign evt_w[GRP_TX]   = tx_evt_i;
    assign evt_w[GRP_MISC] = misc_evt_i;

    irq_bus_decode #(.AW(AW), .DW(DW), .NGRP(NGRP)) u_dec (
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .cause_i    (cause_w),
        .mask_i     (mask_w),
        .mode_i     (mode_w),
        .sum_i      (sum_w),
        .smask_i    (smask_w),
        .strb_o     (strb_w),
        .sum_rd_o   (sum_rd_w),
        .smask_wr_o (smask_wr_w),
        .rdata_o    (rdata_o)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        irq_grp_regs #(.DW(DW)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .strb_i  (strb_w[g]),
            .wdata_i (wdata_i),
            .evt_i   (evt_w[g]),
            .cause_o (cause_w[g]),
            .mask_o  (mask_w[g]),
            .mode_o  (mode_w[g]),
            .any_o   (any_w[g])
        );
    end

    irq_summary #(.DW(DW), .NGRP(NGRP)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_i      (any_w),
        .sum_rd_i   (sum_rd_w),
        .smask_wr_i (smask_wr_w),
        .wdata_i    (wdata_i),
        .sum_o      (sum_w),
        .smask_o    (smask_w),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [AW-1:0]                 addr_i,
    input logic                          wr_en_i,
    input logic                          rd_en_i,
    input logic [DW-1:0]                 wdata_i,
    input logic                          irq_o,
    input logic [DW-1:0]                 evt   [irq_bank_pkg::NGRP],
    input logic [DW-1:0]                 cause [irq_bank_pkg::NGRP],
    input logic [DW-1:0]                 mask  [irq_bank_pkg::NGRP],
    input logic [DW-1:0]                 mode  [irq_bank_pkg::NGRP],
    input logic [irq_bank_pkg::NGRP-1:0] sum,
    input logic [DW-1:0]                 smask
);
    import irq_bank_pkg::*;

    logic [NGRP-1:0] pend;
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            pend[g] = |(cause[g] & ~mask[g]);
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        localparam logic [AW-1:0] BASE = AW'(g * GRP_STRIDE);

        p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] != '0) |=> ((cause[g] & $past(evt[g])) == $past(evt[g])));

        p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == BASE + AW'(OFF_MSET))
            |=> ((mask[g] & $past(wdata_i)) == $past(wdata_i)));

        p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == BASE + AW'(OFF_MCLR))
            |=> ((mask[g] & $past(wdata_i)) == '0));

        p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == BASE + AW'(OFF_CAUSE) && evt[g] == '0)
            |=> ((cause[g] & $past(wdata_i & ~mode[g])) == '0));

        p_sum_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] |=> sum[g]);
    end

    p_sum_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == AW'(ADDR_SUM) && pend == '0) |=> (sum == '0));

    p_irq_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum & ~smask[NGRP-1:0]) == '0 |-> !irq_o);

endmodule

bind irq_cause_bank irq_bank_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .wdata_i (wdata_i),
    .irq_o   (irq_o),
    .evt     (evt_w),
    .cause   (cause_w),
    .mask    (mask_w),
    .mode    (mode_w),
    .sum     (sum_w),
    .smask   (smask_w)
);

// File: tb/tb_irq_cause_bank.sv
module tb_irq_cause_bank;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [DW-1:0] rx_evt = '0, tx_evt = '0, misc_evt = '0;
    logic          irq;

    always #4 clk = ~clk;

    irq_cause_bank #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
        .misc_evt_i(misc_evt), .irq_o(irq)
    );

    int n_chk = 0, n_fail = 0;

    // model state derived from the requirements
    logic [31:0] m_cause [3];
    logic [31:0] m_mask  [3];
    logic [31:0] m_mode  [3];
    logic [2:0]  m_sticky;
    logic [31:0] m_smask;

    function automatic logic [2:0] m_any();
        logic [2:0] a;
        for (int g = 0; g < 3; g++) a[g] = |(m_cause[g] & ~m_mask[g]);
        return a;
    endfunction

    function automatic logic [31:0] m_read(int a);
        if (a < 24) begin
            case (a % 8)
                0: return m_cause[a / 8];
                4: return m_mask[a / 8];
                5: return m_mode[a / 8];
                default: return 32'h0;
            endcase
        end
        if (a == 24) return {29'h0, m_sticky};
        if (a == 25) return m_smask;
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle with optional event pulse on group eg (-1: none)
    task automatic op(int a, bit w, bit r, logic [31:0] d, int eg, logic [31:0] ev, string tag);
        logic [31:0] clr, evg;
        @(negedge clk);
        addr = AW'(a); wr_en = w; rd_en = r; wdata = d;
        rx_evt   = (eg == 0) ? ev : 32'h0;
        tx_evt   = (eg == 1) ? ev : 32'h0;
        misc_evt = (eg == 2) ? ev : 32'h0;
        #2;
        if (r) check(tag, rdata, m_read(a));
        if (r && a == 24) m_sticky = m_any();
        for (int g = 0; g < 3; g++) begin
            clr = 32'h0;
            evg = (eg == g) ? ev : 32'h0;
            if (a == g * 8 && r) clr = clr | m_mode[g];
            if (a == g * 8 && w) clr = clr | (d & ~m_mode[g]);
            m_cause[g] = (m_cause[g] & ~clr) | evg | ((a == g * 8 + 1 && w) ? d : 32'h0);
            if (a == g * 8 + 2 && w) m_mask[g] = m_mask[g] | d;
            if (a == g * 8 + 3 && w) m_mask[g] = m_mask[g] & ~d;
            if (a == g * 8 + 5 && w) m_mode[g] = d;
        end
        if (a == 25 && w) m_smask = d;
        m_sticky = m_sticky | m_any();
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; rx_evt = '0; tx_evt = '0; misc_evt = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        op(a, 1'b1, 1'b0, d, -1, 32'h0, "");
    endtask

    task automatic rd(int a, string tag);
        op(a, 1'b0, 1'b1, 32'h0, -1, 32'h0, tag);
    endtask

    task automatic pulse(int g, logic [31:0] ev);
        op(63, 1'b0, 1'b0, 32'h0, g, ev, "");
    endtask

    task automatic rd_sum(string tag);
        idle(1);
        rd(24, tag);
    endtask

    task automatic chk_irq(string tag);
        idle(2);
        @(negedge clk); #2;
        check(tag, {31'h0, irq}, {31'h0, |(m_sticky & ~m_smask[2:0])});
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        for (int g = 0; g < 3; g++) begin
            m_cause[g] = 32'h0; m_mask[g] = 32'hFFFF_FFFF; m_mode[g] = 32'h0;
        end
        m_sticky = 3'b000; m_smask = 32'hFFFF_FFFF;
        idle(4);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values of every readable location
        for (int g = 0; g < 3; g++) begin
            rd(g * 8 + 0, "R1 cause");
            rd(g * 8 + 4, "R1 mask");
            rd(g * 8 + 5, "R1 mode");
        end
        rd(24, "R1 summary");
        rd(25, "R1 summary mask");
        chk_irq("R1 irq");

        // R2/R3: every bit of every group, write-1 acknowledge
        for (int g = 0; g < 3; g++) begin
            for (int b = 0; b < 32; b++) begin
                pulse(g, 32'h1 << b);
                rd(g * 8, "R2 event latched while masked");
                wr(g * 8, 32'h0);
                rd(g * 8, "R3 zero write and read keep bit");
                wr(g * 8, 32'h1 << b);
                rd(g * 8, "R3 write-1 clears");
            end
        end

        // R5: mask set / clear / readback
        for (int g = 0; g < 3; g++) begin
            wr(g * 8 + 3, 32'hA5A5_5A5A);
            rd(g * 8 + 4, "R5 mask clear");
            wr(g * 8 + 2, 32'h0F0F_0000);
            rd(g * 8 + 4, "R5 mask set");
            wr(g * 8 + 2, 32'hFFFF_FFFF);
            rd(g * 8 + 4, "R5 mask all set");
        end

        // R6 and R4: software set and clear-on-read in misc group
        wr(21, 32'hFFFF_0000);
        rd(21, "R4 mode readback");
        wr(17, 32'h8000_0001);
        rd(16, "R6 cause set");
        wr(17, 32'hFFFF_FFFF);
        rd(16, "R6 cause set all");
        rd(16, "R4 read cleared upper half");
        wr(17, 32'hFFFF_0000);
        wr(16, 32'hFFFF_FFFF);
        rd(16, "R4 write-1 ignored on read-clear bits");
        rd(16, "R4 read clears");
        wr(21, 32'h0);
        rd(16, "R4 all clear");

        // R7/R8/R9: summary and interrupt output
        wr(3, 32'h8);
        pulse(0, 32'h8);
        chk_irq("R9 blocked by summary mask");
        rd_sum("R7 receive bit");
        wr(25, 32'hFFFF_FFF8);
        chk_irq("R9 enabled");
        wr(0, 32'h8);
        chk_irq("R8 summary sticky after ack");
        rd_sum("R8 sticky read");
        chk_irq("R9 low after summary read");
        rd_sum("R8 cleared");
        pulse(1, 32'h80);
        rd_sum("R2 masked cause gives no summary");
        wr(11, 32'h80);
        rd_sum("R7 transmit bit after unmask");
        rd_sum("R8 pending re-sets");
        chk_irq("R9 transmit");
        wr(8, 32'h80);
        rd_sum("R8 sticky");
        rd_sum("R8 clear");
        wr(17, 32'h1);
        wr(19, 32'h1);
        wr(25, 32'hFFFF_FFFE);
        rd_sum("R7 misc bit");
        chk_irq("R9 misc blocked by its summary mask bit");
        wr(25, 32'hFFFF_FFFB);
        chk_irq("R9 misc passed");
        rd(25, "R9 summary mask readback");
        wr(16, 32'h1);
        rd_sum("R8 sticky misc");
        rd_sum("R8 misc clear");
        chk_irq("R9 idle");

        // R10: event collides with clear-on-read and with write-1
        wr(5, 32'h20);
        pulse(0, 32'h20);
        op(0, 1'b0, 1'b1, 32'h0, 0, 32'h20, "R10 read with event");
        rd(0, "R10 bit survived read clear");
        rd(0, "R4 cleared by read");
        pulse(1, 32'h200);
        op(8, 1'b1, 1'b0, 32'h200, 1, 32'h200, "");
        rd(8, "R10 bit survived write-1");
        wr(8, 32'h200);
        rd(8, "R3 cleared after collision");

        // R11: write-only and unmapped addresses
        rd(1, "R11 write-only reads zero");
        rd(10, "R11 write-only reads zero");
        rd(30, "R11 unmapped reads zero");
        rd(7, "R11 unmapped reads zero");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule